// File: doc/BRIEF.md
# Blackman Coefficient Shift-Add Multiplier

This block scales every incoming signed 16-bit sample by the three fixed weights of a three-term Blackman window. The weights are about 0.5, 0.42 and 0.08. It has no general multiplier. The 0.5 weight is a wired arithmetic right shift. The other two weights are sums of shifted copies of the sample, spread over a three-stage adder pipeline.

A downstream combiner multiplies these three products by the window's constant and cosine terms and adds them. The block accepts one sample on every clock. Its three products leave together, with one valid flag, three clocks after the sample enters.

The weights are read as Q2.14 fixed point: 14 fractional bits, so 1.0 is 16384. Each product is computed exactly at 30 bits. It is then brought back to 16 bits by dropping the 14 fractional bits, which rounds toward minus infinity.

Each pipeline register loads only when the valid flag of its own stage is high. Idle cycles therefore leave the outputs untouched.

Top module: `blackman_coef_mul`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and all three products are 0.
- R2: `out_valid` equals `smp_valid` delayed by exactly three clock edges. The products shown with it belong to the sample accepted three edges earlier.
- R3: `prod_half` equals floor(x / 2) for the sample x, which is x times the Q2.14 weight 0x2000 shifted right by 14.
- R4: `prod_main` equals floor(x * 6944 / 16384), using the Q2.14 weight 0x1B20. It is built from the five shifts 12, 11, 9, 8 and 5 and four adders, with at most three adders in series.
- R5: `prod_tail` equals floor(x * 1282 / 16384), using the Q2.14 weight 0x0502. It is built from the three shifts 10, 8 and 1 and two adders.
- R6: Back-to-back samples, one per clock, each produce their own result in order. No result is lost or duplicated.
- R7: On any cycle with `out_valid` low, all three products keep the values they had on the previous cycle.
- R8: The extreme inputs -32768 and 32767, and also -1, 0 and 1, give exact products with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed two's-complement sample |
| out_valid | output | 1 | Products valid, three clocks after the sample |
| prod_half | output | 16 | Sample times 0.5, signed |
| prod_main | output | 16 | Sample times the 0x1B20 weight, signed |
| prod_tail | output | 16 | Sample times the 0x0502 weight, signed |

## Verification
The behaviour hardest to reach from the ports is a bubble inside the pipeline. A stage must keep its partial sums while a later stage is still finishing an older sample. Only then do the late shift terms, taken from the delayed sample copies, line up with the right partial sums.

To reach this, the stimulus first sweeps every 16-bit value back to back. It then runs a stretch where samples arrive only on every third cycle, with values that change each time. A misaligned tap or a missing enable then produces a wrong product or an output that moves during an idle cycle. A short run of the extreme values closes the sequence.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
    localparam int SAMPLE_W = 16;
    localparam int FRAC_W   = 14;

    // Q2.14 weights
    localparam logic [15:0] W_HALF = 16'h2000;
    localparam logic [15:0] W_MAIN = 16'h1B20;
    localparam logic [15:0] W_TAIL = 16'h0502;

    // shift positions of the set bits of W_MAIN
    localparam int SH_M0 = 12;
    localparam int SH_M1 = 11;
    localparam int SH_M2 = 9;
    localparam int SH_M3 = 8;
    localparam int SH_M4 = 5;

    // shift positions of the set bits of W_TAIL
    localparam int SH_T0 = 10;
    localparam int SH_T1 = 8;
    localparam int SH_T2 = 1;

    localparam int PIPE_DEPTH = 3;
endpackage

// File: rtl/bwm_sum2.sv
module bwm_sum2 #(
    parameter int W  = 30,
    parameter int SA = 0,
    parameter int SB = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] q
);
    // one adder level: registered sum of two shifted operands
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= (a <<< SA) + (b <<< SB);
        end
    end
endmodule

// File: rtl/bwm_tap_delay.sv
module bwm_tap_delay #(
    parameter int W     = 16,
    parameter int DEPTH = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DEPTH-1:0]          en,
    input  logic [W-1:0]              d,
    output logic [DEPTH-1:0][W-1:0]   taps
);
    logic [W-1:0] st [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)        st[k] <= '0;
                else if (en[k]) st[k] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)        st[k] <= '0;
                else if (en[k]) st[k] <= st[k-1];
            end
        end
        assign taps[k] = st[k];
    end
endmodule

// File: rtl/bwm_valid_pipe.sv
module bwm_valid_pipe #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vin,
    output logic [DEPTH:0]   vstage
);
    assign vstage[0] = vin;

    for (genvar k = 1; k <= DEPTH; k++) begin : g_v
        always_ff @(posedge clk) begin
            if (rst) vstage[k] <= 1'b0;
            else     vstage[k] <= vstage[k-1];
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (vstage[DEPTH] == 1'b0))
        else $error("valid not cleared by reset");
endmodule

// File: rtl/blackman_coef_mul.sv
module blackman_coef_mul #(
    parameter int DATA_W = bwm_pkg::SAMPLE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] prod_half,
    output logic signed [DATA_W-1:0] prod_main,
    output logic signed [DATA_W-1:0] prod_tail
);
    import bwm_pkg::*;

    localparam int ACC_W = DATA_W + FRAC_W;
    localparam int DEPTH = PIPE_DEPTH;

    logic [DEPTH:0] vs;

    bwm_valid_pipe #(.DEPTH(DEPTH)) u_vpipe (
        .clk(clk), .rst(rst), .vin(smp_valid), .vstage(vs)
    );

    // delayed sample copies for the late shift terms and the 0.5 term
    logic [DEPTH-1:0][DATA_W-1:0] samp;

    bwm_tap_delay #(.W(DATA_W), .DEPTH(DEPTH)) u_samp (
        .clk(clk), .rst(rst), .en(vs[DEPTH-1:0]), .d(smp_data), .taps(samp)
    );

    function automatic logic signed [ACC_W-1:0] widen(input logic [DATA_W-1:0] v);
        return ACC_W'($signed(v));
    endfunction

    logic signed [ACC_W-1:0] x0, x1, x2, zero_w;
    assign x0     = widen(smp_data);
    assign x1     = widen(samp[0]);
    assign x2     = widen(samp[1]);
    assign zero_w = '0;

    // stage 1: three parallel pair sums
    logic signed [ACC_W-1:0] m_hi, m_mid, t_pair;

    bwm_sum2 #(.W(ACC_W), .SA(SH_M0), .SB(SH_M1)) u_m_hi (
        .clk(clk), .rst(rst), .en(vs[0]), .a(x0), .b(x0), .q(m_hi));
    bwm_sum2 #(.W(ACC_W), .SA(SH_M2), .SB(SH_M3)) u_m_mid (
        .clk(clk), .rst(rst), .en(vs[0]), .a(x0), .b(x0), .q(m_mid));
    bwm_sum2 #(.W(ACC_W), .SA(SH_T0), .SB(SH_T1)) u_t_pair (
        .clk(clk), .rst(rst), .en(vs[0]), .a(x0), .b(x0), .q(t_pair));

    // stage 2: join main halves, finish tail
    logic signed [ACC_W-1:0] m_sum, t_fin;

    bwm_sum2 #(.W(ACC_W), .SA(0), .SB(0)) u_m_sum (
        .clk(clk), .rst(rst), .en(vs[1]), .a(m_hi), .b(m_mid), .q(m_sum));
    bwm_sum2 #(.W(ACC_W), .SA(0), .SB(SH_T2)) u_t_fin (
        .clk(clk), .rst(rst), .en(vs[1]), .a(t_pair), .b(x1), .q(t_fin));

    // stage 3: last main term; tail only re-registered (no adder)
    logic signed [ACC_W-1:0] m_fin, t_out;

    bwm_sum2 #(.W(ACC_W), .SA(0), .SB(SH_M4)) u_m_fin (
        .clk(clk), .rst(rst), .en(vs[2]), .a(m_sum), .b(x2), .q(m_fin));
    bwm_sum2 #(.W(ACC_W), .SA(0), .SB(0)) u_t_out (
        .clk(clk), .rst(rst), .en(vs[2]), .a(t_fin), .b(zero_w), .q(t_out));

    assign out_valid = vs[DEPTH];
    assign prod_main = m_fin[FRAC_W +: DATA_W];
    assign prod_tail = t_out[FRAC_W +: DATA_W];
    assign prod_half = $signed(samp[DEPTH-1]) >>> 1;

    // cycles since reset, saturating, so history checks never look before reset
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)           age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R2
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(smp_valid, 3)))
        else $error("valid latency mismatch");

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && !out_valid) |->
            ($stable(prod_half) && $stable(prod_main) && $stable(prod_tail)))
        else $error("products moved while idle");

    // R3
    half_value_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid) |->
            (prod_half == DATA_W'((32'($signed($past(smp_data, 3))) * 32'sd8192) >>> 14)))
        else $error("half product wrong");

    // R5
    tail_value_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid) |->
            (prod_tail == DATA_W'((32'($signed($past(smp_data, 3))) * 32'sd1282) >>> 14)))
        else $error("tail product wrong");

    // R4
    main_value_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid) |->
            (prod_main == DATA_W'((32'($signed($past(smp_data, 3))) * 32'sd6944) >>> 14)))
        else $error("main product wrong");
endmodule

// File: tb/blackman_coef_mul_test.sv
module blackman_coef_mul_test;
    localparam int CLK_PERIOD = 10;
    localparam int RING = 16;

    logic clk = 1'b0;
    logic rst;
    logic smp_valid;
    logic signed [15:0] smp_data;
    logic out_valid;
    logic signed [15:0] prod_half, prod_main, prod_tail;

    blackman_coef_mul uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .out_valid(out_valid), .prod_half(prod_half),
        .prod_main(prod_main), .prod_tail(prod_tail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    int q_val [RING];
    int q_cyc [RING];
    int wr = 0;
    int rd = 0;

    logic signed [15:0] last_h = '0, last_m = '0, last_t = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic signed [15:0] expect_mul(input int x, input int w);
        int p;
        p = x * w;
        return 16'(p >>> 14);
    endfunction

    task automatic check16(input string req, input string what,
                           input logic signed [15:0] act, input logic signed [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int x);
        @(negedge clk);
        smp_valid = v;
        smp_data  = 16'(x);
        if (v) begin
            q_val[wr % RING] = x;
            q_cyc[wr % RING] = cyc;
            wr++;
        end
    endtask

    // output monitor
    always @(negedge clk) begin
        if (running) begin
            if (out_valid) begin
                if (rd >= wr) begin
                    vectors++; fails++;
                    $display("FAIL R6 extra result: actual %0d outputs expected %0d", rd + 1, wr);
                end else begin
                    int x;
                    x = q_val[rd % RING];
                    vectors++;
                    if (cyc - q_cyc[rd % RING] != 3) begin
                        fails++;
                        $display("FAIL R2 latency: actual %0d expected 3", cyc - q_cyc[rd % RING]);
                    end
                    if (x == -32768 || x == 32767 || (x >= -1 && x <= 1)) begin
                        check16("R8", "edge half", prod_half, expect_mul(x, 8192));
                        check16("R8", "edge main", prod_main, expect_mul(x, 6944));
                        check16("R8", "edge tail", prod_tail, expect_mul(x, 1282));
                    end else begin
                        check16("R3", "half", prod_half, expect_mul(x, 8192));
                        check16("R4", "main", prod_main, expect_mul(x, 6944));
                        check16("R5", "tail", prod_tail, expect_mul(x, 1282));
                    end
                    rd++;
                end
                last_h = prod_half; last_m = prod_main; last_t = prod_tail;
            end else begin
                check16("R7", "hold half", prod_half, last_h);
                check16("R7", "hold main", prod_main, last_m);
                check16("R7", "hold tail", prod_tail, last_t);
            end
        end
    end

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; smp_valid = 1'b0; smp_data = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        vectors++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 valid in reset: actual %0b expected 0", out_valid);
        end
        check16("R1", "reset half", prod_half, 16'sd0);
        check16("R1", "reset main", prod_main, 16'sd0);
        check16("R1", "reset tail", prod_tail, 16'sd0);
        rst = 1'b0;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 valid after reset: actual %0b expected 0", out_valid);
        end
        running = 1'b1;

        // R6: full sweep, one sample per clock
        for (int x = -32768; x <= 32767; x++) drive(1'b1, x);

        // R7: sparse samples, bubbles inside the pipeline
        for (int i = 0; i < 300; i++)
            drive(i % 3 == 0, int'($signed(16'(i * 40503 + 17))));
        for (int i = 0; i < 60; i++)
            drive(i % 2 == 1, int'($signed(16'(i * 9973 - 5))));

        // R8: extremes back to back
        drive(1'b1, -32768);
        drive(1'b1, 32767);
        drive(1'b1, -1);
        drive(1'b0, 0);
        drive(1'b1, 1);
        drive(1'b1, 0);
        drive(1'b1, -32768);

        for (int i = 0; i < 6; i++) drive(1'b0, 0);

        // R6: every accepted sample produced exactly one result
        vectors++;
        if (rd != wr) begin
            fails++;
            $display("FAIL R6 result count: actual %0d expected %0d", rd, wr);
        end

        running  = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule